// File: doc/BRIEF.md
# Parent-Cycle Phase-Shifted Clock Pair

This block divides a fast parent clock by a ratio N to form a module clock. It also produces two more copies of that divided clock. The first is an output-phase copy and the second is a sample-phase copy. Each copy lags the module clock by a whole number of parent-clock periods, and a small delay code sets that lag. The two codes sit in separate fields of one control register, which is reached through a simple write strobe and a read-data bus. All three clocks are registered outputs in the parent-clock domain, so they stay frequency-locked to one another.

A code of zero has a special meaning: it places the copy half a module period away from the module clock, which is a 180-degree shift. A nonzero code d delays the copy by d parent periods. That is a step of 360/N degrees per count, and the count wraps modulo N. Software turns degrees into codes.

The divide ratio and both codes are latched only at the rising edge of the module clock. A change made partway through a period therefore takes effect at the next period boundary. A ratio below 2 is treated as 2.

Top module: `phase_clk_pair`

## Requirements
- R1: While `rst` is high, `mod_clk`, `out_clk` and `smp_clk` are low and `rd_data` reads zero.
- R2: A write with `wr_en` high stores `wr_data[9:8]` as the output-phase code and `wr_data[21:20]` as the sample-phase code. `rd_data` returns them at the same positions from the cycle after the write.
- R3: Each delay field is four bits wide (bits 11:8 and 23:20). A write clears the upper two bits of each field, and every bit of `rd_data` outside bits 9:8 and 21:20 reads zero, whatever was written.
- R4: `mod_clk` repeats every N parent cycles and is high for N - floor(N/2) of them. Its first high cycle is the first cycle after reset is released.
- R5: A delay code of 0 makes that phase output a copy of `mod_clk` delayed by floor(N/2) parent cycles, which is 180 degrees for even N.
- R6: A nonzero delay code d makes that phase output a copy of `mod_clk` delayed by d parent cycles. The copy has the same period and high time as `mod_clk`.
- R7: A delay code d that is greater than or equal to N acts as d mod N. For example, code 3 with N=3 gives no delay.
- R8: The divide ratio and both codes are sampled only on the parent edge that starts a new `mod_clk` period. Codes written, or a ratio changed, partway through a period apply from the next period on. The first period after reset uses the codes held before the first write.
- R9: A `div_n` value of 0 or 1 is treated as a ratio of 2.
- R10: The output-phase and sample-phase outputs are set independently. Each follows only its own field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst | input | 1 | Synchronous active-high reset |
| div_n | input | NW | Parent-to-module divide ratio N |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 32 | Control register write data |
| rd_data | output | 32 | Control register read data |
| mod_clk | output | 1 | Undelayed divided module clock |
| out_clk | output | 1 | Output-phase copy of the module clock |
| smp_clk | output | 1 | Sample-phase copy of the module clock |

## Verification
The bench builds the block with its default ratio width of eight bits, so any N from 0 to 255 can be applied through `div_n`. It drives ratios of 0, 1, 2, 3, 4, 5, 6 and 8. This covers the clamp to 2, the wrap of codes 2 and 3 at N=2 and N=3, the floor of the half period for odd N, and a true 180-degree inversion for even N. A mid-period rewrite that changes the ratio and both codes at once shows the period-boundary latching. It also shows that the first period after reset runs on code zero.

// File: rtl/pcp_pkg.sv
package pcp_pkg;
  localparam int REG_W   = 32;
  localparam int LANES   = 2;
  localparam int FIELD_W = 4;
  localparam int CODE_W  = 2;

  // lane 0 = output phase, lane 1 = sample phase
  function automatic int field_lsb(input int lane);
    return (lane == 0) ? 8 : 20;
  endfunction

  typedef logic [LANES-1:0][CODE_W-1:0] code_vec_t;
endpackage

// File: rtl/pcp_ctrl_reg.sv
module pcp_ctrl_reg
  import pcp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output code_vec_t        codes
);
  code_vec_t field_q;
  logic      unused_wr_bits;

  assign unused_wr_bits = ^wr_data;

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_field
      localparam int LSB = field_lsb(i);
      always_ff @(posedge clk) begin
        if (rst) begin
          field_q[i] <= '0;
        end else if (wr_en) begin
          // whole FIELD_W-bit field is rewritten; only the code bits survive
          field_q[i] <= wr_data[LSB +: CODE_W];
        end
      end
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < LANES; i++) begin
      rd_data[field_lsb(i) +: CODE_W] = field_q[i];
    end
  end

  assign codes = field_q;
endmodule

// File: rtl/pcp_base_div.sv
module pcp_base_div
  import pcp_pkg::*;
#(
  parameter int NW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] div_n,
  input  code_vec_t     codes_in,
  output logic [NW-1:0] pos_nxt,
  output logic [NW-1:0] n_use,
  output code_vec_t     codes_use,
  output logic [NW-1:0] n_act,
  output logic          mod_clk
);
  localparam logic [NW-1:0] N_MIN = NW'(2);

  logic [NW-1:0] cnt_q;
  logic          first_q;
  code_vec_t     codes_act;
  logic [NW-1:0] n_clamp;
  logic [NW-1:0] hi_len;
  logic          wrap;

  assign n_clamp = (div_n < N_MIN) ? N_MIN : div_n;
  assign wrap    = first_q || (cnt_q == n_act - NW'(1));

  always_comb begin
    if (wrap) begin
      n_use     = n_clamp;
      codes_use = codes_in;
      pos_nxt   = '0;
    end else begin
      n_use     = n_act;
      codes_use = codes_act;
      pos_nxt   = cnt_q + NW'(1);
    end
  end

  assign hi_len = n_use - (n_use >> 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      first_q   <= 1'b1;
      n_act     <= N_MIN;
      codes_act <= '0;
      mod_clk   <= 1'b0;
    end else begin
      cnt_q     <= pos_nxt;
      first_q   <= 1'b0;
      n_act     <= n_use;
      codes_act <= codes_use;
      mod_clk   <= (pos_nxt < hi_len);
    end
  end
endmodule

// File: rtl/pcp_phase_lane.sv
module pcp_phase_lane
  import pcp_pkg::*;
#(
  parameter int NW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NW-1:0]     pos_nxt,
  input  logic [NW-1:0]     n_use,
  input  logic [CODE_W-1:0] code,
  output logic              ph_clk
);
  logic [NW-1:0] code_x;
  logic [NW-1:0] dly;
  logic [NW:0]   sum;
  logic [NW:0]   ph;
  logic [NW-1:0] hi_len;

  assign code_x = NW'(code);
  assign hi_len = n_use - (n_use >> 1);

  always_comb begin
    if (code_x == '0) begin
      dly = n_use >> 1;
    end else if (code_x >= n_use) begin
      dly = code_x - n_use;
    end else begin
      dly = code_x;
    end
    sum = {1'b0, pos_nxt} + {1'b0, n_use} - {1'b0, dly};
    ph  = (sum >= {1'b0, n_use}) ? (sum - {1'b0, n_use}) : sum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_clk <= 1'b0;
    end else begin
      ph_clk <= (ph < {1'b0, hi_len});
    end
  end
endmodule

// File: rtl/phase_clk_pair.sv
module phase_clk_pair
  import pcp_pkg::*;
#(
  parameter int NW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NW-1:0]    div_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             mod_clk,
  output logic             out_clk,
  output logic             smp_clk
);
  code_vec_t        codes;
  code_vec_t        codes_use;
  logic [NW-1:0]    pos_nxt;
  logic [NW-1:0]    n_use;
  logic [NW-1:0]    n_act;
  logic [LANES-1:0] ph_clk;

  pcp_ctrl_reg u_reg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .codes   (codes)
  );

  pcp_base_div #(.NW(NW)) u_div (
    .clk       (clk),
    .rst       (rst),
    .div_n     (div_n),
    .codes_in  (codes),
    .pos_nxt   (pos_nxt),
    .n_use     (n_use),
    .codes_use (codes_use),
    .n_act     (n_act),
    .mod_clk   (mod_clk)
  );

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      pcp_phase_lane #(.NW(NW)) u_lane (
        .clk     (clk),
        .rst     (rst),
        .pos_nxt (pos_nxt),
        .n_use   (n_use),
        .code    (codes_use[i]),
        .ph_clk  (ph_clk[i])
      );
    end
  endgenerate

  assign out_clk = ph_clk[0];
  assign smp_clk = ph_clk[1];
endmodule

// File: rtl/pcp_chk.sv
module pcp_chk
  import pcp_pkg::*;
#(
  parameter int NW = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             mod_clk,
  input logic             out_clk,
  input logic             smp_clk,
  input logic [NW-1:0]    n_act
);
  localparam int LO = field_lsb(0);
  localparam int HI = field_lsb(1);

  logic          mod_prev;
  logic          seen;
  logic [NW-1:0] run;
  logic [NW-1:0] nref;
  logic          rise;
  logic          fall;
  logic [REG_W-1:0] code_mask;

  assign rise = mod_clk && !mod_prev;
  assign fall = !mod_clk && mod_prev;

  always_comb begin
    code_mask = '0;
    code_mask[LO +: CODE_W] = '1;
    code_mask[HI +: CODE_W] = '1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mod_prev <= 1'b0;
      seen     <= 1'b0;
      run      <= '0;
      nref     <= '0;
    end else begin
      mod_prev <= mod_clk;
      if (rise) begin
        seen <= 1'b1;
        run  <= NW'(1);
        nref <= n_act;
      end else begin
        run <= run + NW'(1);
      end
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!mod_clk && !out_clk && !smp_clk && rd_data == '0));

  // R2
  field_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (rd_data[LO +: CODE_W] == $past(wr_data[LO +: CODE_W]) &&
               rd_data[HI +: CODE_W] == $past(wr_data[HI +: CODE_W])));

  // R3
  spare_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data & ~code_mask) == '0);

  // R4
  period_len_chk: assert property (@(posedge clk) disable iff (rst)
    (rise && seen) |-> (run == nref));

  // R4
  high_len_chk: assert property (@(posedge clk) disable iff (rst)
    (fall && seen) |-> (run == nref - (nref >> 1)));

  // R9
  ratio_floor_chk: assert property (@(posedge clk) disable iff (rst)
    n_act >= NW'(2));
endmodule

bind phase_clk_pair pcp_chk #(.NW(NW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .mod_clk (mod_clk),
  .out_clk (out_clk),
  .smp_clk (smp_clk),
  .n_act   (n_act)
);

// File: tb/phase_clk_pair_bench.sv
module phase_clk_pair_bench;
  localparam int NW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NW-1:0] div_n = '0;
  logic          wr_en = 1'b0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   rd_data;
  logic          mod_clk, out_clk, smp_clk;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  phase_clk_pair #(.NW(NW)) u_phase_clk_pair (
    .clk(clk), .rst(rst), .div_n(div_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .mod_clk(mod_clk), .out_clk(out_clk), .smp_clk(smp_clk)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    n_checks++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  function automatic int eff_dly(input int code, input int n);
    if (code == 0) return n / 2;
    return code % n;
  endfunction

  function automatic int clamp_n(input int n);
    return (n < 2) ? 2 : n;
  endfunction

  function automatic logic [31:0] pack(input int co, input int cs);
    return (32'(co) << 8) | (32'(cs) << 20);
  endfunction

  task automatic do_reset(input int n);
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; div_n = NW'(n);
    repeat (3) @(negedge clk);
  endtask

  // R1: reset state at the ports
  task automatic t_reset();
    do_reset(4);
    check("R1 clocks low", {29'd0, mod_clk, out_clk, smp_clk}, 32'd0);
    check("R1 rd_data", rd_data, 32'd0);
  endtask

  // R2 R3 R10: register fields
  task automatic t_regs();
    do_reset(4);
    rst = 1'b0;
    wr_en = 1'b1; wr_data = 32'hFFFF_FFFF;
    @(negedge clk);
    wr_en = 1'b0;
    check("R3 spare bits zero", rd_data, 32'h0030_0300);
    wr_en = 1'b1; wr_data = 32'h0010_0200;
    @(negedge clk);
    wr_en = 1'b0;
    check("R2 field positions", rd_data, 32'h0010_0200);
    wr_en = 1'b1; wr_data = 32'hFF0C_FCFF;
    @(negedge clk);
    wr_en = 1'b0;
    check("R10 fields independent", rd_data, 32'h0000_0000);
  endtask

  // Cycle-level run against a spec model; optional mid-run change at chg
  task automatic run_case(input string tag, input int n0, input int co0, input int cs0,
                          input int ncyc, input int chg, input int n1, input int co1, input int cs1);
    int pos, cur_n, c_o, c_s, reg_o, reg_s, nin, hi;
    bit first;
    logic em, eo, es;
    do_reset(n0);
    rst = 1'b0;
    pos = 0; cur_n = 2; c_o = 0; c_s = 0; reg_o = 0; reg_s = 0; first = 1'b1;
    for (int j = 0; j < ncyc; j++) begin
      if (j == 0) begin
        wr_en = 1'b1; wr_data = pack(co0, cs0); div_n = NW'(n0);
      end else if (j == chg) begin
        wr_en = 1'b1; wr_data = pack(co1, cs1); div_n = NW'(n1);
      end else begin
        wr_en = 1'b0;
      end
      @(posedge clk);
      nin = clamp_n((chg >= 0 && j >= chg) ? n1 : n0);
      if (first || pos == cur_n - 1) begin
        pos = 0; cur_n = nin; c_o = reg_o; c_s = reg_s;
      end else begin
        pos++;
      end
      first = 1'b0;
      if (j == 0) begin reg_o = co0; reg_s = cs0; end
      else if (j == chg) begin reg_o = co1; reg_s = cs1; end
      hi = cur_n - cur_n / 2;
      em = (pos < hi);
      eo = (((pos - eff_dly(c_o, cur_n) + cur_n) % cur_n) < hi);
      es = (((pos - eff_dly(c_s, cur_n) + cur_n) % cur_n) < hi);
      @(negedge clk);
      check(tag, {29'd0, mod_clk, out_clk, smp_clk}, {29'd0, em, eo, es});
    end
    wr_en = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_regs();
    run_case("R4 R6 R10 n4 d1/d3",       4, 1, 3, 40, -1, 0, 0, 0);
    run_case("R5 n8 half period",         8, 0, 2, 48, -1, 0, 0, 0);
    run_case("R5 n5 odd half",            5, 0, 1, 40, -1, 0, 0, 0);
    run_case("R7 n2 wrap codes 3/2",      2, 3, 2, 24, -1, 0, 0, 0);
    run_case("R7 n3 wrap code 3",         3, 3, 0, 30, -1, 0, 0, 0);
    run_case("R9 n1 clamped",             1, 1, 0, 20, -1, 0, 0, 0);
    run_case("R9 n0 clamped",             0, 0, 1, 20, -1, 0, 0, 0);
    run_case("R8 mid-period change",      6, 1, 2, 60, 14, 4, 3, 0);
    run_case("R8 ratio change only",      4, 2, 1, 50, 9, 8, 2, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule